// File: doc/BRIEF.md
# Auto-Increment Register File Front End

This block is the register access layer that sits behind a byte-oriented serial slave. A bit-level receiver (not part of this block) turns the serial line into a stream of strobes. These strobes mark a start condition, a stop condition, an address byte, a received data byte and a request for a byte to send back. The block answers with an acknowledge decision for every byte it accepts, and with read data for every read request it accepts. It holds five configuration registers that a brightness generator downstream uses: two prescalers, two duty values and an LED output selector. It also offers a read-only view of the four LED pin levels.

A write transaction starts with a matching address whose direction bit is 0. The first data byte after it loads a control byte, which holds a register pointer and an auto-increment flag. Each later data byte writes the register the pointer selects. A read transaction returns the register at the current pointer for each read request. The pointer is kept across transactions, so a master can set it in a short write and then read from it after a repeated start. A slave address that does not match is refused, and the block stays silent until the next start condition.

Top module: `ledreg_front`

## Requirements
- R1: An address byte received after a start is accepted when bits 7:1 equal `110001` followed by the `addr_strap` level. One cycle after `addr_valid`, `ack_valid`=1 and `ack`=1. Bit 0 of the address byte selects read (1) or write (0).
- R2: A non-matching address byte gets `ack_valid`=1 with `ack`=0 one cycle later. Until the next start, all later data bytes and read requests produce no `ack_valid`, no `rd_valid` and no register change.
- R3: The first data byte after an accepted write address is the control byte. It is acknowledged and writes no configuration register. Its bit 4 becomes the auto-increment flag and its bits 2:0 become the register pointer.
- R4: Each later data byte in that write is acknowledged and stored in the register the pointer selects: 1 = prescaler 0, 2 = duty 0, 3 = prescaler 1, 4 = duty 1, 5 = LED selector. The new value shows on the matching output port one cycle after `wr_valid`.
- R5: After an accepted read address, each `rd_req` gives `rd_valid`=1 one cycle later, with `rd_data` holding the register at the pointer.
- R6: When the flag is 1, the pointer advances by one after every data write or data read. After an access at pointer 5, 6 or 7 it returns to 0.
- R7: When the flag is 0, every data write and data read uses the same pointer.
- R8: Pointer 0 reads as `{4'b0000, pin_level}`, sampled in the `rd_req` cycle. Writes to it are acknowledged and change no register.
- R9: Pointers 6 and 7 read as 00h. Writes to them are acknowledged and discarded.
- R10: After reset the pointer is 0, the flag is 0, both prescalers are 00h, both duty registers are 80h and the LED selector is 00h. Strobes are ignored until a start.
- R11: A stop ends the transaction, and bytes after it are ignored until a start. The pointer and the flag survive stop and repeated start.
- R12: `ack_valid` and `rd_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap | input | 1 | Variant strap, the lowest bit of the slave address |
| bus_start | input | 1 | Start or repeated start seen |
| bus_stop | input | 1 | Stop seen |
| addr_valid | input | 1 | `rx_byte` holds the address byte |
| wr_valid | input | 1 | `rx_byte` holds a received data byte |
| rx_byte | input | 8 | Received byte |
| rd_req | input | 1 | Master wants the next byte |
| pin_level | input | 4 | Current LED pin levels |
| ack_valid | output | 1 | Acknowledge decision is valid |
| ack | output | 1 | 1 = acknowledge, 0 = refuse |
| rd_valid | output | 1 | `rd_data` is valid |
| rd_data | output | 8 | Byte to transmit |
| psc0_q | output | 8 | Prescaler 0 |
| pwm0_q | output | 8 | Duty 0 |
| psc1_q | output | 8 | Prescaler 1 |
| pwm1_q | output | 8 | Duty 1 |
| led_sel_q | output | 8 | LED output selector |

## Verification
The in-RTL assertions check the following on every cycle:
- the acknowledge or refusal that follows each address decision;
- silence while idle;
- the pointer holding when the flag is clear, and its return to 0 after the last slot;
- zero upper bits on INPUT reads and zero data from the unused slots;
- writes to INPUT leaving every register untouched;
- the two output strobes never overlapping.

Other behaviour only the bench scenarios can show, by comparing against a behavioural model on every clock:
- the exact register contents after sequences of auto-incremented writes;
- the read order across a wrap through INPUT;
- a pointer carried across a stop and a repeated start;
- the strap selecting between the two addresses.

// File: rtl/ledreg_pkg.sv
package ledreg_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_CTRL,
      ST_WDATA,
      ST_READ
   } fe_state_t;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/ledreg_addr_match.sv
module ledreg_addr_match #(
   parameter int unsigned ADDR_W   = 7,
   parameter logic [6:0]  BASE     = 7'b1100010,
   parameter bit          STRAP_EN = 1'b1
) (
   input  logic [7:0] addr_byte,
   input  logic       strap,
   output logic       match,
   output logic       is_read
);
   logic [ADDR_W-1:0] expect_addr;

   if (ADDR_W != 7) begin : g_bad_width
      $error("ledreg_addr_match: ADDR_W must be 7");
   end

   if (STRAP_EN) begin : g_strap
      assign expect_addr = {BASE[ADDR_W-1:1], strap};
   end else begin : g_fixed
      logic unused_strap;
      assign unused_strap = strap;
      assign expect_addr  = BASE;
   end

   assign match   = (addr_byte[7:1] == expect_addr);
   assign is_read = addr_byte[0];
endmodule

// File: rtl/ledreg_ptr.sv
module ledreg_ptr #(
   parameter int unsigned PTR_W    = 3,
   parameter int unsigned NUM_REGS = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             ai_in,
   input  logic [PTR_W-1:0] ptr_in,
   input  logic             step,
   output logic             ai_q,
   output logic [PTR_W-1:0] ptr_q
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

   if (NUM_REGS > (1 << PTR_W) || NUM_REGS < 2) begin : g_bad_regs
      $error("ledreg_ptr: NUM_REGS out of range for PTR_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ai_q  <= 1'b0;
         ptr_q <= '0;
      end else if (load) begin
         ai_q  <= ai_in;
         ptr_q <= ptr_in;
      end else if (step && ai_q) begin
         ptr_q <= (ptr_q >= LAST) ? '0 : ptr_q + 1'b1;
      end
   end

   // R7: pointer holds when the flag is clear
   a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ai_q && !load) |=> (ptr_q == $past(ptr_q)));

   // R6: wrap back to slot 0 after the last slot or a hole
   a_r6_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step && ai_q && !load && ptr_q >= LAST) |=> (ptr_q == '0));
endmodule

// File: rtl/ledreg_bank.sv
module ledreg_bank #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned PTR_W    = 3,
   parameter int unsigned NUM_REGS = 6,
   parameter int unsigned PIN_W    = 4,
   parameter logic [NUM_REGS*DATA_W-1:0] DEFAULTS = '0
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic                           rd_en,
   input  logic [PTR_W-1:0]               ptr,
   input  logic [DATA_W-1:0]              wr_data,
   input  logic [PIN_W-1:0]               pin_level,
   output logic                           rd_valid,
   output logic [DATA_W-1:0]              rd_data,
   output logic [(NUM_REGS-1)*DATA_W-1:0] cfg_flat
);
   localparam int unsigned SLOTS = 1 << PTR_W;

   if (PIN_W >= DATA_W) begin : g_bad_pins
      $error("ledreg_bank: PIN_W must be below DATA_W");
   end

   logic [DATA_W-1:0] view [SLOTS];

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      if (i == 0) begin : g_input
         assign view[i] = {{(DATA_W-PIN_W){1'b0}}, pin_level};
      end else if (i < NUM_REGS) begin : g_store
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= DEFAULTS[i*DATA_W +: DATA_W];
            else if (wr_en && ptr == PTR_W'(i))
               q <= wr_data;
         end
         assign view[i] = q;
         assign cfg_flat[(i-1)*DATA_W +: DATA_W] = q;
      end else begin : g_hole
         assign view[i] = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= view[ptr];
      end
   end

   // R8: INPUT reads carry zeros above the pin bits
   a_r8_input_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && ptr == '0) |=> (rd_data[DATA_W-1:PIN_W] == '0));

   // R8: a write aimed at INPUT leaves every register unchanged
   a_r8_input_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ptr == '0) |=> $stable(cfg_flat));

   // R9: unused slots read as zero
   a_r9_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && ptr >= PTR_W'(NUM_REGS)) |=> (rd_data == '0));
endmodule

// File: rtl/ledreg_front.sv
module ledreg_front
   import ledreg_pkg::*;
#(
   parameter int unsigned PIN_W      = 4,
   parameter logic [6:0]  ADDR_BASE  = 7'b1100010,
   parameter bit          STRAP_EN   = 1'b1,
   parameter logic [7:0]  DEF_PSC0   = 8'h00,
   parameter logic [7:0]  DEF_PWM0   = 8'h80,
   parameter logic [7:0]  DEF_PSC1   = 8'h00,
   parameter logic [7:0]  DEF_PWM1   = 8'h80,
   parameter logic [7:0]  DEF_LEDSEL = 8'h00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr_strap,
   input  logic             bus_start,
   input  logic             bus_stop,
   input  logic             addr_valid,
   input  logic             wr_valid,
   input  logic [7:0]       rx_byte,
   input  logic             rd_req,
   input  logic [PIN_W-1:0] pin_level,
   output logic             ack_valid,
   output logic             ack,
   output logic             rd_valid,
   output logic [7:0]       rd_data,
   output logic [7:0]       psc0_q,
   output logic [7:0]       pwm0_q,
   output logic [7:0]       psc1_q,
   output logic [7:0]       pwm1_q,
   output logic [7:0]       led_sel_q
);
   localparam int unsigned NUM_REGS = 6;
   localparam int unsigned PTR_W    = 3;
   localparam int unsigned AI_BIT   = 4;
   localparam logic [NUM_REGS*BYTE_W-1:0] DEFAULTS =
      {DEF_LEDSEL, DEF_PWM1, DEF_PSC1, DEF_PWM0, DEF_PSC0, 8'h00};

   fe_state_t st_q, st_d;
   logic match, is_read;
   logic quiet, addr_ev, ctrl_we, data_we, rd_en;
   logic ai_q;
   logic [PTR_W-1:0] ptr_q;
   logic [(NUM_REGS-1)*BYTE_W-1:0] cfg_flat;

   ledreg_addr_match #(
      .ADDR_W(7), .BASE(ADDR_BASE), .STRAP_EN(STRAP_EN)
   ) addr_i (
      .addr_byte(rx_byte), .strap(addr_strap), .match(match), .is_read(is_read)
   );

   assign quiet   = !bus_start && !bus_stop;
   assign addr_ev = quiet && (st_q == ST_ADDR)  && addr_valid;
   assign ctrl_we = quiet && (st_q == ST_CTRL)  && wr_valid;
   assign data_we = quiet && (st_q == ST_WDATA) && wr_valid;
   assign rd_en   = quiet && (st_q == ST_READ)  && rd_req;

   always_comb begin
      st_d = st_q;
      if (bus_start)    st_d = ST_ADDR;
      else if (bus_stop) st_d = ST_IDLE;
      else if (addr_ev) st_d = !match ? ST_IDLE : (is_read ? ST_READ : ST_CTRL);
      else if (ctrl_we) st_d = ST_WDATA;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         ack_valid <= 1'b0;
         ack       <= 1'b0;
      end else begin
         st_q      <= st_d;
         ack_valid <= addr_ev || ctrl_we || data_we;
         if (addr_ev)                 ack <= match;
         else if (ctrl_we || data_we) ack <= 1'b1;
      end
   end

   ledreg_ptr #(.PTR_W(PTR_W), .NUM_REGS(NUM_REGS)) ptr_i (
      .clk(clk), .rst_n(rst_n), .load(ctrl_we),
      .ai_in(rx_byte[AI_BIT]), .ptr_in(rx_byte[PTR_W-1:0]),
      .step(data_we || rd_en), .ai_q(ai_q), .ptr_q(ptr_q)
   );

   ledreg_bank #(
      .DATA_W(BYTE_W), .PTR_W(PTR_W), .NUM_REGS(NUM_REGS),
      .PIN_W(PIN_W), .DEFAULTS(DEFAULTS)
   ) bank_i (
      .clk(clk), .rst_n(rst_n), .wr_en(data_we), .rd_en(rd_en),
      .ptr(ptr_q), .wr_data(rx_byte), .pin_level(pin_level),
      .rd_valid(rd_valid), .rd_data(rd_data), .cfg_flat(cfg_flat)
   );

   assign psc0_q    = cfg_flat[0*BYTE_W +: BYTE_W];
   assign pwm0_q    = cfg_flat[1*BYTE_W +: BYTE_W];
   assign psc1_q    = cfg_flat[2*BYTE_W +: BYTE_W];
   assign pwm1_q    = cfg_flat[3*BYTE_W +: BYTE_W];
   assign led_sel_q = cfg_flat[4*BYTE_W +: BYTE_W];

   // R1: matching address is acknowledged next cycle
   a_r1_addr_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_ev && match) |=> (ack_valid && ack));

   // R2: non-matching address is refused next cycle
   a_r2_addr_nack: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_ev && !match) |=> (ack_valid && !ack));

   // R2, R11: silent while idle
   a_r2_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |=> (!ack_valid && !rd_valid));

   // R12: response strobes never overlap
   a_r12_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ack_valid, rd_valid}));

   // R3: the control byte never touches a configuration register
   a_r3_ctrl_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we |=> $stable(cfg_flat));
endmodule

// File: tb/ledreg_front_tb.sv
module ledreg_front_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic addr_strap = 1'b0;
   logic bus_start = 1'b0, bus_stop = 1'b0, addr_valid = 1'b0, wr_valid = 1'b0, rd_req = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic [3:0] pin_level = 4'hF;
   logic ack_valid, ack, rd_valid;
   logic [7:0] rd_data, psc0_q, pwm0_q, psc1_q, pwm1_q, led_sel_q;

   always #2 clk = ~clk;   // 250 MHz

   ledreg_front dut_i (
      .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap),
      .bus_start(bus_start), .bus_stop(bus_stop), .addr_valid(addr_valid),
      .wr_valid(wr_valid), .rx_byte(rx_byte), .rd_req(rd_req),
      .pin_level(pin_level), .ack_valid(ack_valid), .ack(ack),
      .rd_valid(rd_valid), .rd_data(rd_data), .psc0_q(psc0_q),
      .pwm0_q(pwm0_q), .psc1_q(psc1_q), .pwm1_q(pwm1_q), .led_sel_q(led_sel_q)
   );

   // behavioural reference: 0 idle, 1 expect address, 2 expect control, 3 writing, 4 reading
   int m_st, m_ptr, m_ai;
   int m_reg [8];
   bit m_ack_v, m_ack, m_rd_v;
   int m_rd;
   int vectors = 0, miscompares = 0, cycles = 0;
   bit done = 0;
   string cur_req = "R10";

   task automatic m_advance();
      if (m_ai != 0) m_ptr = (m_ptr >= 5) ? 0 : m_ptr + 1;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_ptr = 0; m_ai = 0; m_ack_v = 0; m_rd_v = 0;
         m_reg[1] = 8'h00; m_reg[2] = 8'h80; m_reg[3] = 8'h00;
         m_reg[4] = 8'h80; m_reg[5] = 8'h00;
      end else begin
         m_ack_v = 0; m_rd_v = 0;
         if (bus_start) m_st = 1;
         else if (bus_stop) m_st = 0;
         else if (m_st == 1 && addr_valid) begin
            m_ack_v = 1;
            m_ack = (rx_byte[7:1] == {6'b110001, addr_strap});
            m_st = !m_ack ? 0 : (rx_byte[0] ? 4 : 2);
         end else if (m_st == 2 && wr_valid) begin
            m_ack_v = 1; m_ack = 1;
            m_ai = rx_byte[4]; m_ptr = rx_byte[2:0]; m_st = 3;
         end else if (m_st == 3 && wr_valid) begin
            m_ack_v = 1; m_ack = 1;
            if (m_ptr >= 1 && m_ptr <= 5) m_reg[m_ptr] = rx_byte;
            m_advance();
         end else if (m_st == 4 && rd_req) begin
            m_rd_v = 1;
            m_rd = (m_ptr == 0) ? int'(pin_level) : (m_ptr <= 5 ? m_reg[m_ptr] : 0);
            m_advance();
         end
      end
   end

   task automatic chk(string what, int got, int exp);
      if (got != exp) begin
         miscompares++;
         $display("FAIL %s %s got %02h exp %02h", cur_req, what, got, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         vectors++;
         chk("ack_valid", ack_valid, m_ack_v);
         chk("rd_valid", rd_valid, m_rd_v);
         if (m_ack_v) chk("ack", ack, m_ack);
         if (m_rd_v) chk("rd_data", rd_data, m_rd);
         chk("psc0", psc0_q, m_reg[1]);
         chk("pwm0", pwm0_q, m_reg[2]);
         chk("psc1", psc1_q, m_reg[3]);
         chk("pwm1", pwm1_q, m_reg[4]);
         chk("led_sel", led_sel_q, m_reg[5]);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000 && !done) begin
         done = 1;
         miscompares++;
         $display("FAIL watchdog expired in %s", cur_req);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   task automatic clear_strobes();
      bus_start = 0; bus_stop = 0; addr_valid = 0; wr_valid = 0; rd_req = 0;
   endtask
   task automatic do_start();
      @(negedge clk); clear_strobes(); bus_start = 1; @(negedge clk); clear_strobes();
   endtask
   task automatic do_stop();
      @(negedge clk); clear_strobes(); bus_stop = 1; @(negedge clk); clear_strobes();
   endtask
   task automatic send_addr(logic [7:0] b);
      @(negedge clk); clear_strobes(); addr_valid = 1; rx_byte = b; @(negedge clk); clear_strobes();
   endtask
   task automatic send_byte(logic [7:0] b);
      @(negedge clk); clear_strobes(); wr_valid = 1; rx_byte = b; @(negedge clk); clear_strobes();
   endtask
   task automatic read_req();
      @(negedge clk); clear_strobes(); rd_req = 1; @(negedge clk); clear_strobes();
   endtask

   initial begin
      cur_req = "R10";
      repeat (3) @(negedge clk);
      rst_n = 1;
      send_byte(8'h55);               // R10: ignored before any start
      read_req();
      repeat (2) @(negedge clk);

      cur_req = "R4";                 // R1, R3, R4, R6: auto-increment write sweep with wrap
      do_start(); send_addr(8'hC4); send_byte(8'h11);
      send_byte(8'h10); send_byte(8'h40); send_byte(8'h20); send_byte(8'hC0); send_byte(8'h55);
      cur_req = "R8";
      send_byte(8'hEE);               // lands on INPUT, ignored
      cur_req = "R6";
      send_byte(8'h33);               // after wrap, slot 1
      do_stop();

      cur_req = "R5";                 // R5, R6, R8: read across the wrap
      pin_level = 4'hA;
      do_start(); send_addr(8'hC4); send_byte(8'h12);
      do_start(); send_addr(8'hC5);
      for (int k = 0; k < 7; k++) begin
         if (k == 4) pin_level = 4'h5;
         read_req();
      end
      do_stop();

      cur_req = "R7";                 // fixed pointer
      do_start(); send_addr(8'hC4); send_byte(8'h03);
      send_byte(8'hAA); send_byte(8'hBB);
      do_start(); send_addr(8'hC5); read_req(); read_req(); do_stop();

      cur_req = "R9";                 // unused slots
      do_start(); send_addr(8'hC4); send_byte(8'h16);
      send_byte(8'h77); send_byte(8'h88); send_byte(8'h99); send_byte(8'h44);
      do_start(); send_addr(8'hC4); send_byte(8'h07); send_byte(8'h66);
      do_start(); send_addr(8'hC5); read_req(); read_req(); do_stop();

      cur_req = "R2";                 // wrong variant address then ignored traffic
      addr_strap = 0;
      do_start(); send_addr(8'hC6); send_byte(8'h01); send_byte(8'hFF); read_req();
      send_addr(8'hC4);
      cur_req = "R1";
      addr_strap = 1;
      do_start(); send_addr(8'hC6); send_byte(8'h02); send_byte(8'h5A);
      do_start(); send_addr(8'hC4);   // old variant now refused
      do_start(); send_addr(8'h62);   // wrong upper bits

      cur_req = "R11";                // stop, ignored bytes, pointer kept
      do_start(); send_addr(8'hC6); send_byte(8'h14); send_byte(8'h21);
      do_stop(); send_byte(8'h99); read_req();
      do_start(); send_addr(8'hC7); read_req(); read_req();
      do_stop();

      cur_req = "R12";                // mixed random traffic
      for (int n = 0; n < 600; n++) begin
         int op;
         op = $urandom_range(0, 6);
         case (op)
            0: do_start();
            1: do_stop();
            2: begin
               int pick;
               pick = $urandom_range(0, 4);
               send_addr(pick == 4 ? 8'($urandom) : 8'(8'hC4 + pick));
            end
            3: send_byte(8'($urandom));
            4: send_byte(8'($urandom_range(0, 7)) | (($urandom_range(0, 1) != 0) ? 8'h10 : 8'h00));
            5: read_req();
            default: begin
               pin_level = 4'($urandom);
               if ($urandom_range(0, 7) == 0) addr_strap = ~addr_strap;
               @(negedge clk);
            end
         endcase
      end
      repeat (3) @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule